// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Receive Checker

This block watches a byte-wide receive stream and decides whether each frame arrived intact. Every accepted byte, the four trailing check bytes included, passes through one CRC-32 byte step. The check bytes get no special handling. When the frame's last byte has been absorbed, the 32-bit register is compared with the fixed value that an error-free frame always leaves behind. The result is a one-cycle `done` pulse with an `fcs_ok` flag beside it.

The input is a valid/ready stream with a last-byte marker. The checker never applies back-pressure: `in_ready` stays high, so a byte is consumed on every clock edge where `in_valid` is high. Cycles with `in_valid` low carry nothing. The register is preset to all ones at reset and again right after every frame end. A new frame may therefore begin on the very next cycle.

Top module: `fcs_rx_checker`

## Requirements
- R1: While reset is held and on the first sampled cycle after it, `done` and `fcs_ok` are low.
- R2: `in_ready` is high at every cycle out of reset, so each cycle with `in_valid` high moves exactly one byte.
- R3: Each accepted byte updates the register with the generator 0x04C11DB7. Bit 0 of the byte enters first and is XORed with register bit 31, and the register shifts toward its MSB. The register holds all ones before a frame's first byte.
- R4: `done` is high for exactly one cycle, in the cycle after the edge that accepts a byte with `in_last` high. It is low at every other time.
- R5: With `done`, `fcs_ok` is high exactly when the register after the last byte equals 0xC704DD7B, compared bit for bit with no reversal or inversion. The sender's check field is the complement of the reflected CRC-32 of the payload, sent least significant byte first, and such a frame reports good.
- R6: `fcs_ok` is never high while `done` is low.
- R7: A cycle with `in_valid` low leaves the register unchanged and produces no `done`, whatever `in_data` and `in_last` carry.
- R8: The preset is reloaded on the edge that accepts the last byte. A frame starting on the next cycle is checked correctly.
- R9: A single flipped bit anywhere in the payload makes `fcs_ok` low at `done`.
- R10: A single flipped bit in the four check bytes makes `fcs_ok` low at `done`.
- R11: A frame made only of the four check bytes of an empty payload (00 00 00 00) reports good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is present |
| in_ready | output | 1 | Always high out of reset; checker never stalls |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame (last check byte) |
| done | output | 1 | One-cycle pulse after the frame's last byte |
| fcs_ok | output | 1 | Frame passed the residue check; valid with `done` |

## Verification
Good frames come from a model of the transmit side that computes the reflected CRC-32 and appends it. The payloads are incrementing counts, all-zero bytes, all-one bytes and a mixed pattern, each one exercising a different set of the generator's feedback taps. Streams with idle gaps carry misleading data and last flags on the idle cycles, which tells apart a design that gates on valid from one that does not. Back-to-back frames show that the preset returns in time. Single-bit flips in the payload and in the check field must both read as bad. An empty-payload frame tests the all-zero check field at the preset's boundary.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [CRC_W-1:0] GEN_POLY   = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] GOOD_RESID = 32'hC704_DD7B;
  localparam logic [CRC_W-1:0] CRC_PRESET = {CRC_W{1'b1}};
endpackage

// File: rtl/crc_byte_step.sv
// One byte of CRC update, unrolled one bit per stage, LSB of the byte first.
module crc_byte_step #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int unsigned STAGES = DATA_W + 1;

  logic [CRC_W-1:0] chain [STAGES];

  assign chain[0] = crc_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb          = chain[i][CRC_W-1] ^ data_in[i];
    assign chain[i+1]  = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : {CRC_W{1'b0}});
  end

  assign crc_out = chain[DATA_W];
endmodule

// File: rtl/crc_accum.sv
// Running CRC register: advances on accepted bytes, presets after frame end.
module crc_accum #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] PRESET = {CRC_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             frame_end,
  input  logic [CRC_W-1:0] crc_next,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= PRESET;
    else if (take)       crc_q <= frame_end ? PRESET : crc_next;
  end

  // R7: idle cycles leave the register alone
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));

  // R8: preset present right after a frame end
  p_preset_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && frame_end) |=> (crc_q == PRESET));
endmodule

// File: rtl/fcs_verdict.sv
// Registers the end-of-frame pulse and the residue comparison.
module fcs_verdict #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hC704_DD7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             frame_end,
  input  logic [CRC_W-1:0] crc_next,
  output logic             done,
  output logic             fcs_ok
);
  logic hit;
  assign hit = (crc_next == RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      fcs_ok <= 1'b0;
    end else begin
      done   <= take & frame_end;
      fcs_ok <= take & frame_end & hit;
    end
  end

  // R6: status only qualifies alongside the pulse
  p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_ok |-> done);
endmodule

// File: rtl/fcs_rx_checker.sv
module fcs_rx_checker
  import fcs_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned REG_W  = CRC_W,
  parameter logic [REG_W-1:0] POLY    = GEN_POLY,
  parameter logic [REG_W-1:0] PRESET  = CRC_PRESET,
  parameter logic [REG_W-1:0] RESIDUE = GOOD_RESID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              done,
  output logic              fcs_ok
);
  logic             take;
  logic [REG_W-1:0] crc_q;
  logic [REG_W-1:0] crc_next;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  crc_byte_step #(.DATA_W(DATA_W), .CRC_W(REG_W), .POLY(POLY)) u_step (
    .crc_in (crc_q),
    .data_in(in_data),
    .crc_out(crc_next)
  );

  crc_accum #(.CRC_W(REG_W), .PRESET(PRESET)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .frame_end(in_last),
    .crc_next (crc_next),
    .crc_q    (crc_q)
  );

  fcs_verdict #(.CRC_W(REG_W), .RESIDUE(RESIDUE)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .frame_end(in_last),
    .crc_next (crc_next),
    .done     (done),
    .fcs_ok   (fcs_ok)
  );

  // R4: a pulse only follows an accepted last byte
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R4: an accepted last byte always yields a pulse
  p_last_gives_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> done);

  // R2: never stalls the source
  p_always_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/fcs_rx_checker_test.sv
module fcs_rx_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       done;
  logic       fcs_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] fbuf [0:255];
  bit   exp_done = 1'b0;
  bit   exp_ok   = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  fcs_rx_checker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .done(done), .fcs_ok(fcs_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reflected CRC-32 of the first n bytes, complemented (transmit-side check field)
  function automatic logic [31:0] tx_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {24'h0, fbuf[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic void append_fcs(input int n);
    logic [31:0] f = tx_fcs(n);
    for (int k = 0; k < 4; k++) fbuf[n+k] = f[8*k +: 8];
  endfunction

  // One cycle: check outputs caused by the previous edge, then drive the next inputs.
  task automatic beat(input bit v, input logic [7:0] d, input bit l, input bit good);
    @(negedge clk);
    check(tag, {31'h0, done}, {31'h0, exp_done}, "done");
    check(exp_done ? tag : "R6", {31'h0, fcs_ok}, {31'h0, exp_ok}, "fcs_ok");
    check("R2", {31'h0, in_ready}, 32'h1, "in_ready");
    in_valid = v; in_data = d; in_last = l;
    exp_done = v && l;
    exp_ok   = v && l && good;
  endtask

  task automatic send(input int len, input int gap, input bit good);
    for (int k = 0; k < len; k++) begin
      beat(1'b1, fbuf[k], k == len - 1, good);
      if (gap > 0 && k != len - 1)
        for (int g = 0; g < gap; g++) beat(1'b0, ~fbuf[k], 1'b1, 1'b0);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) beat(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    tag = "R1";
    #1;
    check("R1", {31'h0, done}, 32'h0, "done in reset");
    check("R1", {31'h0, fcs_ok}, 32'h0, "fcs_ok in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_good_patterns();
    tag = "R3";
    for (int k = 0; k < 60; k++) fbuf[k] = 8'(k);
    append_fcs(60); send(64, 0, 1'b1); idle(2);
    tag = "R5";
    for (int k = 0; k < 20; k++) fbuf[k] = 8'h00;
    append_fcs(20); send(24, 0, 1'b1); idle(2);
    for (int k = 0; k < 17; k++) fbuf[k] = 8'hFF;
    append_fcs(17); send(21, 0, 1'b1); idle(2);
    for (int k = 0; k < 46; k++) fbuf[k] = 8'((k * 37) ^ 8'h5A);
    append_fcs(46); send(50, 0, 1'b1); idle(2);
  endtask

  task automatic t_gaps();
    tag = "R7";
    for (int k = 0; k < 30; k++) fbuf[k] = 8'(8'hC3 + k * 11);
    append_fcs(30); send(34, 2, 1'b1); idle(2);
  endtask

  task automatic t_back_to_back();
    tag = "R8";
    for (int k = 0; k < 12; k++) fbuf[k] = 8'(k + 100);
    append_fcs(12); send(16, 0, 1'b1);
    for (int k = 0; k < 9; k++) fbuf[k] = 8'(8'hE0 ^ k);
    append_fcs(9); send(13, 0, 1'b1);
    tag = "R4";
    idle(3);
  endtask

  task automatic t_payload_flip();
    tag = "R9";
    for (int k = 0; k < 40; k++) fbuf[k] = 8'(k * 3);
    append_fcs(40); fbuf[17] ^= 8'h10; send(44, 0, 1'b0); idle(1);
    for (int k = 0; k < 40; k++) fbuf[k] = 8'(k * 3);
    append_fcs(40); fbuf[0] ^= 8'h01; send(44, 0, 1'b0); idle(1);
  endtask

  task automatic t_fcs_flip();
    tag = "R10";
    for (int k = 0; k < 25; k++) fbuf[k] = 8'(8'hA5 - k);
    append_fcs(25); fbuf[27] ^= 8'h80; send(29, 0, 1'b0); idle(1);
    append_fcs(25); fbuf[28] ^= 8'h02; send(29, 0, 1'b0); idle(1);
  endtask

  task automatic t_empty_payload();
    tag = "R11";
    append_fcs(0);
    check("R11", {fbuf[3], fbuf[2], fbuf[1], fbuf[0]}, 32'h0, "empty-payload check field");
    send(4, 0, 1'b1); idle(2);
  endtask

  initial begin
    t_reset();
    t_good_patterns();
    t_gaps();
    t_back_to_back();
    t_payload_flip();
    t_fcs_flip();
    t_empty_payload();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule